// File: doc/BRIEF.md
# Burst Handshake Timing Monitor

This block is a passive, synthesizable monitor for a burst handshake built on three active-low controls: a burst request, an output enable and a data acknowledge. Every input is sampled on the rising clock edge. A burst opens when the request is seen low on a clock after it was seen high on the clock before. The monitor then expects output enable and acknowledge to be low together within a bounded number of clocks. Once they are both low, they must stay low together for a minimum number of consecutive clocks. The burst request must also stay low on every one of those clocks.

A burst that meets all of these rules produces a one-cycle pass pulse. A burst that breaks any of them produces a one-cycle error pulse and also sets a flag that holds until reset. The monitor tracks one burst at a time and then goes back to waiting for the next start. It drives nothing onto the bus it watches. The inputs must already be synchronous to its clock.

Top module: `burst_handshake_mon`

## Requirements
- R1: A synchronous, active-high reset clears the pass pulse, the error pulse and the sticky flag, and abandons any burst in progress. After reset the request must be sampled high at least once before a low sample can start a burst.
- R2: A burst starts only on a clock where the request is sampled low (0) and the previous sample was high (1). A request that stays low starts nothing more.
- R3: Output enable and acknowledge must both be sampled low either on the start clock or on one of the next MAX_LAG clocks (default 2). If they are not, the error pulse rises after the edge that samples start+MAX_LAG.
- R4: When MIN_RUN consecutive samples (default 4) show output enable, acknowledge and the request all low, the pass pulse rises after the edge that samples the last of them.
- R5: If output enable or acknowledge goes high before MIN_RUN joint-low samples have been counted, the error pulse rises after the edge that samples the break.
- R6: If the request is sampled high on any clock where output enable and acknowledge are both low, the error pulse rises after that edge.
- R7: Output enable may go low on an earlier clock than acknowledge. The run count starts on the first clock where both are low.
- R8: A new request start seen while a burst is being checked is ignored, and the deadline from the first start still applies.
- R9: The sticky error flag rises together with the first error pulse and stays high until reset.
- R10: The pass and error pulses each last exactly one clock and are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| burst_n | input | 1 | Burst request, active low |
| oe_n | input | 1 | Output enable, active low |
| ack_n | input | 1 | Data acknowledge, active low |
| pass_o | output | 1 | One-cycle pulse when a burst meets all rules |
| err_o | output | 1 | One-cycle pulse when a burst breaks a rule |
| err_sticky_o | output | 1 | Error flag, held until reset |

## Verification
The bench places joint-low on the last legal clock and one clock too late. A monitor with an off-by-one deadline would raise an error on the first case or stay silent on the second. It breaks the run after two joint clocks and also raises the request in the middle of the window. A monitor that only counts clocks, or only checks the request at the start, would wrongly pulse pass in these cases. It re-triggers the request while the monitor is waiting, where a monitor that restarted would miss the deadline. It also holds the request low straight out of reset, where a monitor that treats reset as a prior high sample would start a false burst.

// File: rtl/bhm_pkg.sv
package bhm_pkg;
    localparam int DEF_MAX_LAG = 2;
    localparam int DEF_MIN_RUN = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;
endpackage

// File: rtl/bhm_fall_det.sv
module bhm_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic line_n,
    output logic fall_o
);
    logic seen_high_d, seen_high_q;

    always_comb begin
        seen_high_d = line_n;
    end

    always_ff @(posedge clk) begin
        if (rst) seen_high_q <= 1'b0;
        else     seen_high_q <= seen_high_d;
    end

    assign fall_o = seen_high_q & ~line_n;
endmodule

// File: rtl/bhm_seq.sv
module bhm_seq
    import bhm_pkg::*;
#(
    parameter int MAX_LAG = DEF_MAX_LAG,
    parameter int MIN_RUN = DEF_MIN_RUN
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic burst_n,
    input  logic oe_n,
    input  logic ack_n,
    output logic pass_o,
    output logic err_o,
    output logic sticky_o
);
    localparam int LAG_W = (MAX_LAG < 2) ? 1 : $clog2(MAX_LAG);
    localparam int RUN_W = (MIN_RUN < 2) ? 1 : $clog2(MIN_RUN);
    localparam logic [LAG_W-1:0] LAG_LAST = LAG_W'(MAX_LAG - 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(MIN_RUN - 1);
    localparam bit ONE_RUN = (MIN_RUN <= 1);

    typedef struct packed {
        phase_e           phase;
        logic [LAG_W-1:0] lag;
        logic [RUN_W-1:0] run;
        logic             pass;
        logic             err;
        logic             sticky;
    } seq_t;

    seq_t cur_q, nxt_d;
    logic joint, hold;

    always_comb begin
        joint = ~oe_n & ~ack_n;
        hold  = joint & ~burst_n;
        nxt_d      = cur_q;
        nxt_d.pass = 1'b0;
        nxt_d.err  = 1'b0;
        unique case (cur_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    if (hold) begin
                        if (ONE_RUN) nxt_d.pass = 1'b1;
                        else begin
                            nxt_d.run   = RUN_W'(1);
                            nxt_d.phase = PH_RUN;
                        end
                    end else begin
                        nxt_d.lag   = '0;
                        nxt_d.phase = PH_WAIT;
                    end
                end
            end
            PH_WAIT: begin
                if (joint) begin
                    if (burst_n) begin
                        nxt_d.err   = 1'b1;
                        nxt_d.phase = PH_IDLE;
                    end else if (ONE_RUN) begin
                        nxt_d.pass  = 1'b1;
                        nxt_d.phase = PH_IDLE;
                    end else begin
                        nxt_d.run   = RUN_W'(1);
                        nxt_d.phase = PH_RUN;
                    end
                end else if (cur_q.lag == LAG_LAST) begin
                    nxt_d.err   = 1'b1;
                    nxt_d.phase = PH_IDLE;
                end else begin
                    nxt_d.lag = cur_q.lag + LAG_W'(1);
                end
            end
            PH_RUN: begin
                if (!hold) begin
                    nxt_d.err   = 1'b1;
                    nxt_d.phase = PH_IDLE;
                end else if (cur_q.run == RUN_LAST) begin
                    nxt_d.pass  = 1'b1;
                    nxt_d.phase = PH_IDLE;
                end else begin
                    nxt_d.run = cur_q.run + RUN_W'(1);
                end
            end
            default: nxt_d.phase = PH_IDLE;
        endcase
        if (nxt_d.err) nxt_d.sticky = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '{phase: PH_IDLE, lag: '0, run: '0,
                       pass: 1'b0, err: 1'b0, sticky: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pass_o   = cur_q.pass;
    assign err_o    = cur_q.err;
    assign sticky_o = cur_q.sticky;
endmodule

// File: rtl/burst_handshake_mon.sv
module burst_handshake_mon
    import bhm_pkg::*;
#(
    parameter int MAX_LAG = DEF_MAX_LAG,
    parameter int MIN_RUN = DEF_MIN_RUN
) (
    input  logic clk,
    input  logic rst,
    input  logic burst_n,
    input  logic oe_n,
    input  logic ack_n,
    output logic pass_o,
    output logic err_o,
    output logic err_sticky_o
);
    logic start;

    bhm_fall_det u_fall (
        .clk    (clk),
        .rst    (rst),
        .line_n (burst_n),
        .fall_o (start)
    );

    bhm_seq #(
        .MAX_LAG (MAX_LAG),
        .MIN_RUN (MIN_RUN)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .burst_n  (burst_n),
        .oe_n     (oe_n),
        .ack_n    (ack_n),
        .pass_o   (pass_o),
        .err_o    (err_o),
        .sticky_o (err_sticky_o)
    );
endmodule

// File: rtl/bhm_checker.sv
module bhm_checker (
    input logic clk,
    input logic rst,
    input logic burst_n,
    input logic oe_n,
    input logic ack_n,
    input logic pass_o,
    input logic err_o,
    input logic err_sticky_o
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!pass_o && !err_o && !err_sticky_o));

    assert_pass_after_hold_R4: assert property (@(posedge clk) disable iff (rst)
        pass_o |-> $past(!oe_n && !ack_n && !burst_n));

    assert_err_sets_flag_R9: assert property (@(posedge clk) disable iff (rst)
        err_o |-> err_sticky_o);

    assert_flag_holds_R9: assert property (@(posedge clk) disable iff (rst)
        err_sticky_o |=> err_sticky_o);

    assert_not_both_R10: assert property (@(posedge clk) disable iff (rst)
        !(pass_o && err_o));

    assert_pass_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        pass_o |=> !pass_o);

    assert_err_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o);
endmodule

bind burst_handshake_mon bhm_checker chk_i (
    .clk          (clk),
    .rst          (rst),
    .burst_n      (burst_n),
    .oe_n         (oe_n),
    .ack_n        (ack_n),
    .pass_o       (pass_o),
    .err_o        (err_o),
    .err_sticky_o (err_sticky_o)
);

// File: tb/burst_handshake_mon_tb_top.sv
module burst_handshake_mon_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic burst_n = 1'b0, oe_n = 1'b0, ack_n = 1'b0;
    logic pass_o, err_o, err_sticky_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit exp_sticky = 1'b0;

    typedef struct {
        bit    p;
        bit    e;
        bit    s;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    burst_handshake_mon dut_i (
        .clk          (clk),
        .rst          (rst),
        .burst_n      (burst_n),
        .oe_n         (oe_n),
        .ack_n        (ack_n),
        .pass_o       (pass_o),
        .err_o        (err_o),
        .err_sticky_o (err_sticky_o)
    );

    task automatic step(input bit r, input bit b, input bit o, input bit a,
                        input bit ep, input bit ee, input string tag);
        exp_t item;
        @(negedge clk);
        rst = r; burst_n = b; oe_n = o; ack_n = a;
        if (r) exp_sticky = 1'b0;
        else if (ee) exp_sticky = 1'b1;
        item.p = ep; item.e = ee; item.s = exp_sticky; item.tag = tag;
        sb_q.push_back(item);
    endtask

    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            checks++;
            if (pass_o !== it.p || err_o !== it.e || err_sticky_o !== it.s) begin
                errors++;
                $display("FAIL %s: pass/err/sticky got %b%b%b expected %b%b%b",
                         it.tag, pass_o, err_o, err_sticky_o, it.p, it.e, it.s);
            end
        end
    end

    initial begin
        // R1: reset with request low, then stay low: no start (R2)
        step(1, 0, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 0, 0, 0, "R1");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, "R1/R2");

        // R7/R4: enable first, acknowledge one clock later, pass after 4 joint
        step(0, 1, 1, 1, 0, 0, "R7");
        step(0, 0, 0, 1, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 1, 0, "R4");
        step(0, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, "R2");

        // R3: joint low exactly on start+2 is legal
        step(0, 1, 1, 1, 0, 0, "R3");
        step(0, 0, 1, 1, 0, 0, "R3");
        step(0, 0, 1, 1, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 1, 0, "R3");

        // R3/R9: only enable by start+2 -> error, flag held
        step(0, 1, 1, 1, 0, 0, "R3");
        step(0, 0, 1, 1, 0, 0, "R3");
        step(0, 0, 0, 1, 0, 0, "R3");
        step(0, 0, 0, 1, 0, 1, "R3");
        step(0, 1, 1, 1, 0, 0, "R9");
        step(0, 1, 1, 1, 0, 0, "R9");

        // R1: reset in the middle of a run
        step(0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 0, 0, 0, "R1");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0, "R1");

        // R5: acknowledge drops after two joint clocks
        step(0, 1, 1, 1, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 1, 0, 1, "R5");
        step(0, 1, 1, 1, 0, 0, "R5");

        // R6: request high inside the joint window
        step(1, 1, 1, 1, 0, 0, "R6");
        step(0, 1, 1, 1, 0, 0, "R6");
        step(0, 0, 0, 0, 0, 0, "R6");
        step(0, 0, 0, 0, 0, 0, "R6");
        step(0, 1, 0, 0, 0, 1, "R6");
        step(0, 1, 1, 1, 0, 0, "R6");

        // R8: retrigger during wait is ignored; original deadline applies
        step(0, 0, 1, 1, 0, 0, "R8");
        step(0, 1, 1, 1, 0, 0, "R8");
        step(0, 0, 1, 1, 0, 1, "R8");
        step(0, 1, 1, 1, 0, 0, "R8");

        // R2: a fresh start after going high works again
        step(0, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 1, 0, "R2");
        step(0, 1, 1, 1, 0, 0, "R2");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule